// File: doc/BRIEF.md
# Delay Code Programming Register

This block holds the binary code that selects the step of a programmable delay. The code can be loaded in two ways. In parallel mode the code pins pass through a level-sensitive hold stage. In serial mode the value is shifted into a staging register and takes effect only when the load is closed. A mode input selects the loading method. One latch-enable input gates loading in both modes. In serial mode three of the code pins change role: one becomes the serial clock, one the serial data input, and one the serial data output.

All pins are sampled on the block's system clock through a synchronizer of configurable depth. Serial-clock and latch-enable transitions are detected on that clock. The serial output presents the most significant bit of the staging register. Units can therefore be chained: the serial output of one unit drives the serial data input of the next, and all units share the serial clock and the latch-enable.

Top module: `dly_code_reg`

## Requirements
- R1: While `rst_n` is low, `code_o` and the staging register are all zeros, so `sdo_o` is 0.
- R2: With `ser_sel_i` = 0 and `le_i` = 1, `code_o` follows `code_i` no later than SYNC_STAGES+2 system clocks after a pin change.
- R3: With `ser_sel_i` = 0 and `le_i` = 0, `code_o` keeps its value whatever `code_i` does.
- R4: With `ser_sel_i` = 1 and `le_i` = 1, each rising edge on `code_i[1]` (serial clock) shifts the staging register up by one bit and takes `code_i[2]` (serial data) into bit 0. A byte is therefore sent most significant bit first.
- R5: With `ser_sel_i` = 1, `code_o` does not change during shifting or on any change of the code pins. It changes only at the activation of R6.
- R6: With `ser_sel_i` = 1, a high-to-low transition of `le_i` copies the staging register into `code_o`.
- R7: `sdo_o` is bit 7 of the staging register. The previous contents leave most significant bit first. The output changes only after the shift caused by a serial-clock rising edge.
- R8: Rising serial-clock edges while `le_i` = 0 leave the staging register unchanged.
- R9: In a chain of two units, 16 serial bits load the downstream unit with the first byte sent and the upstream unit with the second byte.
- R10: `sdo_oe_o` is 1 in serial mode and 0 in parallel mode. In parallel mode, edges on `code_i[1]` do not shift the staging register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_sel_i | input | 1 | Loading mode: 0 parallel, 1 serial |
| le_i | input | 1 | Latch enable: opens the parallel hold stage / frames a serial load |
| code_i | input | CODE_W | Code pins; in serial mode bit 1 is serial clock and bit 2 serial data in |
| code_o | output | CODE_W | Active delay code |
| sdo_o | output | 1 | Serial data out (pad for code pin bit 0 in serial mode) |
| sdo_oe_o | output | 1 | Output enable for the serial data out pad |

## Verification
The bench builds two units with CODE_W = 8. The first uses SYNC_STAGES = 2. The second uses SYNC_STAGES = 0 and takes its serial data input from the first unit's serial output. This exercises both the registered and the pass-through synchronizer variants, and it makes a 16-bit cascade load observable at both units' code outputs. Because the two latencies differ, the chain is shown to work when the downstream unit samples its data before the upstream unit shifts.

// File: rtl/dly_code_pkg.sv
package dly_code_pkg;

   typedef enum logic {
      PROG_PAR = 1'b0,
      PROG_SER = 1'b1
   } prog_mode_e;

   typedef enum logic {
      EDGE_RISE = 1'b0,
      EDGE_FALL = 1'b1
   } edge_kind_e;

   function automatic bit pins_distinct(input int a, input int b, input int c);
      return (a != b) && (a != c) && (b != c);
   endfunction

   function automatic bit pin_in_range(input int idx, input int width);
      return (idx >= 0) && (idx < width);
   endfunction

endpackage

// File: rtl/dly_code_sync.sv
module dly_code_sync #(
   parameter int N      = 10,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d,
   output logic [N-1:0] q
);

   if (N < 1) begin : g_bad_n
      $error("dly_code_sync: N must be at least 1");
   end
   if (STAGES < 0) begin : g_bad_stages
      $error("dly_code_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_pass
      assign q = d;
   end else begin : g_chain
      logic [N-1:0] ff [STAGES];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
               ff[s] <= '0;
            end
         end else begin
            ff[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
               ff[s] <= ff[s-1];
            end
         end
      end

      assign q = ff[STAGES-1];
   end

endmodule

// File: rtl/dly_code_edge.sv
module dly_code_edge
   import dly_code_pkg::*;
#(
   parameter edge_kind_e KIND = EDGE_RISE
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic hit
);

   logic d_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         d_q <= 1'b0;
      end else begin
         d_q <= d;
      end
   end

   if (KIND == EDGE_RISE) begin : g_rise
      assign hit = d & ~d_q;
   end else begin : g_fall
      assign hit = ~d & d_q;
   end

endmodule

// File: rtl/dly_code_shift.sv
module dly_code_shift #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift_en,
   input  logic         din,
   output logic [W-1:0] shreg
);

   if (W < 2) begin : g_bad_w
      $error("dly_code_shift: W must be at least 2");
   end

   logic [W-1:0] nxt;

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (i == 0) begin : g_lsb
         assign nxt[i] = din;
      end else begin : g_up
         assign nxt[i] = shreg[i-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '0;
      end else if (shift_en) begin
         shreg <= nxt;
      end
   end

endmodule

// File: rtl/dly_code_active.sv
module dly_code_active
   import dly_code_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  prog_mode_e   mode,
   input  logic         le_lvl,
   input  logic         le_fall,
   input  logic [W-1:0] par_code,
   input  logic [W-1:0] ser_code,
   output logic [W-1:0] code
);

   logic         load;
   logic [W-1:0] load_val;

   always_comb begin
      load     = 1'b0;
      load_val = par_code;
      unique case (mode)
         PROG_PAR: begin
            load     = le_lvl;
            load_val = par_code;
         end
         PROG_SER: begin
            load     = le_fall;
            load_val = ser_code;
         end
         default: begin
            load     = 1'b0;
            load_val = par_code;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code <= '0;
      end else if (load) begin
         code <= load_val;
      end
   end

endmodule

// File: rtl/dly_code_reg.sv
module dly_code_reg
   import dly_code_pkg::*;
#(
   parameter int CODE_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int DOUT_BIT    = 0,
   parameter int SCLK_BIT    = 1,
   parameter int DIN_BIT     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_sel_i,
   input  logic              le_i,
   input  logic [CODE_W-1:0] code_i,
   output logic [CODE_W-1:0] code_o,
   output logic              sdo_o,
   output logic              sdo_oe_o
);

   localparam int SYNC_W  = CODE_W + 2;
   localparam int MODE_IX = CODE_W + 1;
   localparam int LE_IX   = CODE_W;

   if (CODE_W < 3) begin : g_bad_width
      $error("dly_code_reg: CODE_W must be at least 3");
   end
   if (!pin_in_range(DOUT_BIT, CODE_W) || !pin_in_range(SCLK_BIT, CODE_W) ||
       !pin_in_range(DIN_BIT, CODE_W)) begin : g_bad_range
      $error("dly_code_reg: serial pin index outside the code bus");
   end
   if (!pins_distinct(DOUT_BIT, SCLK_BIT, DIN_BIT)) begin : g_bad_share
      $error("dly_code_reg: serial pins must be distinct code bits");
   end

   logic [SYNC_W-1:0] raw_pins;
   logic [SYNC_W-1:0] sync_pins;
   logic [CODE_W-1:0] code_s;
   logic              mode_s;
   logic              le_s;
   logic              sclk_s;
   logic              din_s;
   logic              le_fall;
   logic              sclk_rise;
   logic              shift_en;
   logic [CODE_W-1:0] shreg;
   prog_mode_e        mode_e;

   assign raw_pins = {ser_sel_i, le_i, code_i};

   dly_code_sync #(
      .N      (SYNC_W),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_pins),
      .q     (sync_pins)
   );

   assign code_s = sync_pins[CODE_W-1:0];
   assign mode_s = sync_pins[MODE_IX];
   assign le_s   = sync_pins[LE_IX];
   assign sclk_s = code_s[SCLK_BIT];
   assign din_s  = code_s[DIN_BIT];
   assign mode_e = prog_mode_e'(mode_s);

   dly_code_edge #(
      .KIND (EDGE_FALL)
   ) u_le_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (le_s),
      .hit   (le_fall)
   );

   dly_code_edge #(
      .KIND (EDGE_RISE)
   ) u_sclk_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (sclk_s),
      .hit   (sclk_rise)
   );

   assign shift_en = (mode_e == PROG_SER) && le_s && sclk_rise;

   dly_code_shift #(
      .W (CODE_W)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (shift_en),
      .din      (din_s),
      .shreg    (shreg)
   );

   dly_code_active #(
      .W (CODE_W)
   ) u_active (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode_e),
      .le_lvl   (le_s),
      .le_fall  (le_fall),
      .par_code (code_s),
      .ser_code (shreg),
      .code     (code_o)
   );

   assign sdo_o    = shreg[CODE_W-1];
   assign sdo_oe_o = (mode_e == PROG_SER);

endmodule

// File: rtl/dly_code_reg_chk.sv
module dly_code_reg_chk #(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         mode_s,
   input logic         le_s,
   input logic         le_fall,
   input logic         sclk_rise,
   input logic         din_s,
   input logic [W-1:0] code_s,
   input logic [W-1:0] shreg,
   input logic [W-1:0] code_o
);

   logic [W-1:0] exp_shift;
   assign exp_shift = {shreg[W-2:0], din_s};

   assert_reset_R1: assert property (@(posedge clk)
      !rst_n |=> (code_o == '0) && (shreg == '0));

   assert_par_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_s && le_s) |=> (code_o == $past(code_s)));

   assert_par_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_s && !le_s) |=> $stable(code_o));

   assert_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_s && le_s && sclk_rise) |=> (shreg == $past(exp_shift)));

   assert_ser_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_s && !le_fall) |=> $stable(code_o));

   assert_activate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_s && le_fall) |=> (code_o == $past(shreg)));

   // R8 and R10: no shift outside an enabled serial-clock edge
   assert_no_shift_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(mode_s && le_s && sclk_rise) |=> $stable(shreg));

endmodule

bind dly_code_reg dly_code_reg_chk #(
   .W (CODE_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode_s    (mode_s),
   .le_s      (le_s),
   .le_fall   (le_fall),
   .sclk_rise (sclk_rise),
   .din_s     (din_s),
   .code_s    (code_s),
   .shreg     (shreg),
   .code_o    (code_o)
);

// File: tb/dly_code_reg_tb.sv
`timescale 1ns/1ps
module dly_code_reg_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sel = 1'b0;
   logic       le = 1'b0;
   logic [7:0] pins = 8'h00;
   logic [7:0] code_a, code_b;
   logic       sdo_a, sdo_b, oe_a, oe_b;
   logic [7:0] pins_b;
   int         n_chk = 0;
   int         n_bad = 0;
   bit         done = 1'b0;

   always #2 clk = ~clk;

   assign pins_b = {pins[7:3], sdo_a, pins[1:0]};

   dly_code_reg #(.CODE_W(8), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .ser_sel_i(sel), .le_i(le),
      .code_i(pins), .code_o(code_a), .sdo_o(sdo_a), .sdo_oe_o(oe_a));

   dly_code_reg #(.CODE_W(8), .SYNC_STAGES(0)) u_dut_b (
      .clk(clk), .rst_n(rst_n), .ser_sel_i(sel), .le_i(le),
      .code_i(pins_b), .code_o(code_b), .sdo_o(sdo_b), .sdo_oe_o(oe_b));

   // {le, code pins, expected code_o}, parallel mode
   localparam logic [16:0] VEC [8] = '{
      {1'b1, 8'hA5, 8'hA5},
      {1'b0, 8'h3C, 8'hA5},
      {1'b0, 8'hFF, 8'hA5},
      {1'b1, 8'h00, 8'h00},
      {1'b1, 8'hFF, 8'hFF},
      {1'b0, 8'h12, 8'hFF},
      {1'b1, 8'h81, 8'h81},
      {1'b1, 8'h7E, 8'h7E}
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      end
   endtask

   task automatic pulse_sclk();
      pins[1] = 1'b1;
      wclk(6);
      pins[1] = 1'b0;
      wclk(6);
   endtask

   // Send one byte MSB first; before each edge the serial output shows old[i] (R7)
   task automatic shift_byte(input logic [7:0] v, input logic [7:0] old_v,
                             input logic [7:0] held);
      for (int i = 7; i >= 0; i--) begin
         pins[2] = v[i];
         wclk(4);
         chk("R7 sdo", {7'b0, sdo_a}, {7'b0, old_v[i]});
         pulse_sclk();
         if (i == 4) chk("R5 code held mid-shift", code_a, held);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      wclk(3);
      chk("R1 reset code", code_a, 8'h00);
      chk("R1 reset sdo", {7'b0, sdo_a}, 8'h00);
      chk("R10 oe parallel", {7'b0, oe_a}, 8'h00);
      rst_n = 1'b1;
      wclk(2);

      for (int i = 0; i < 8; i++) begin
         le   = VEC[i][16];
         pins = VEC[i][15:8];
         wclk(8);
         chk(VEC[i][16] ? "R2 parallel follow" : "R3 parallel hold", code_a, VEC[i][7:0]);
      end

      // R10: serial-clock pin toggled in parallel mode must not shift
      pins = 8'h04;
      wclk(6);
      pulse_sclk();
      pulse_sclk();
      pins = 8'h7E;
      wclk(8);
      le = 1'b0;
      wclk(8);
      chk("R10 no shift in parallel", {7'b0, sdo_a}, 8'h00);

      sel = 1'b1;
      wclk(8);
      chk("R10 oe serial", {7'b0, oe_a}, 8'h01);
      chk("R5 code kept on mode switch", code_a, 8'h7E);

      // R8: edges with le low are ignored
      pins[2] = 1'b1;
      pulse_sclk();
      pulse_sclk();
      pulse_sclk();
      chk("R8 ignored edges", {7'b0, sdo_a}, 8'h00);

      le = 1'b1;
      wclk(8);
      shift_byte(8'hA7, 8'h00, 8'h7E);
      chk("R5 code before activation", code_a, 8'h7E);
      le = 1'b0;
      wclk(8);
      chk("R4 R6 activate first byte", code_a, 8'hA7);

      // R5 pin changes in serial mode with le low; R8 edges ignored
      pins[7:3] = 5'b10101;
      pins[0]   = 1'b1;
      pins[2]   = 1'b0;
      pulse_sclk();
      pulse_sclk();
      wclk(4);
      chk("R5 pins ignored in serial", code_a, 8'hA7);
      chk("R8 staging kept", {7'b0, sdo_a}, 8'h01);

      le = 1'b1;
      wclk(8);
      shift_byte(8'h5A, 8'hA7, 8'hA7);
      le = 1'b0;
      wclk(8);
      chk("R4 second byte", code_a, 8'h5A);

      // R9 cascade: downstream group first
      le = 1'b1;
      wclk(8);
      shift_byte(8'hC3, 8'h5A, 8'h5A);
      shift_byte(8'h96, 8'hC3, 8'h5A);
      le = 1'b0;
      wclk(8);
      chk("R9 upstream code", code_a, 8'h96);
      chk("R9 downstream code", code_b, 8'hC3);

      sel  = 1'b0;
      le   = 1'b1;
      pins = 8'h33;
      wclk(8);
      chk("R2 back to parallel", code_a, 8'h33);
      chk("R10 oe back low", {7'b0, oe_a}, 8'h00);
      chk("R2 pass-through variant", code_b, 8'h37);

      rst_n = 1'b0;
      wclk(2);
      chk("R1 reset mid-run code", code_a, 8'h00);
      chk("R1 reset mid-run sdo", {7'b0, sdo_a}, 8'h00);
      rst_n = 1'b1;
      wclk(2);

      summary();
      $finish;
   end

endmodule